// File: doc/BRIEF.md
# Interrupt Class Selector

This block chooses which interruption a processor core takes next. A synchronous exception, either a program check or a supervisor call, is granted without looking at any mask. With no synchronous exception present, the asynchronous classes are tried in a fixed order: machine check, then external, then I/O. Each is gated by its own mask bit in the current program status word. The block keeps pending state of its own: a small occupancy counter for machine-check requests, one for queued external requests, and one for each I/O subclass. It also keeps two sticky flags for the clock-comparator and CPU-timer sources.

The core raises `take_i` whenever it can accept an interruption. On that clock edge the block registers a one-hot class grant, with the selected I/O subclass or external interruption code where they apply. In the same edge it removes the served request from its queue or flag. Saving the old status word, fetching the new one and running the handler are left to the core. All pins are plain control and status. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `intr_class_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `grant_o`, `io_sub_o`, `ext_code_o` and `pend_o` are all zero, and every queue count and sticky flag is cleared.
- R2: When `take_i` is high and `pgm_i` is high, the grant is the program class, `grant_o` = 5'b00001. Otherwise, when `svc_i` is high, the grant is the supervisor-call class, 5'b00010. Both apply whatever the mask bits are.
- R3: The machine-check class (bit 2, 5'b00100) is tried first among the asynchronous classes, and only while `psw_mchk_i` is set. With that mask clear, a pending machine check is skipped and the lower classes are tried.
- R4: If `psw_mchk_i` is set and a machine check is pending but `cr_mchk_en_i` is clear, a take produces no grant at all, lower classes included. The machine check stays pending (`pend_o[0]` stays 1).
- R5: The external class (bit 3, 5'b01000) is tried second, only while `psw_ext_i` is set. A queued external request wins and reports code 16'h0000. Otherwise a clock-comparator request wins and reports 16'h1004. Otherwise a CPU-timer request wins and reports 16'h1005. `ext_code_o` is valid in the grant cycle.
- R6: The I/O class (bit 4, 5'b10000) is tried last, only while `psw_io_i` is set. Subclasses are scanned from 0 upward, and the first non-empty one whose bit in `cr_io_en_i` is 1 is served. Its number appears on `io_sub_o` and its count drops by one.
- R7: A non-empty subclass whose enable bit is 0 is never served and stays pending. If it is the only pending subclass, a take gives no grant, and `pend_o[2]` stays 1 until every subclass is empty.
- R8: `pend_o` is {I/O, external, machine check}, bits 2..0. Bit 0 is 1 while the machine-check count is non-zero. Bit 1 is 1 while the external count is non-zero or a clock-comparator or CPU-timer flag is set. Bit 2 is 1 while any I/O subclass count is non-zero. Serving a timer source clears that source's flag.
- R9: `grant_o` has at most one bit set. It goes high only in the cycle after a clock edge at which `take_i` was high, and it lasts one cycle per take.
- R10: Each queue holds at most 4 requests. A push to a full queue is ignored, unless the same queue is being served in that cycle. A push and a serve of the same queue in one cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_i | input | 1 | Core can accept an interruption this cycle |
| pgm_i | input | 1 | Program exception present |
| svc_i | input | 1 | Supervisor-call exception present |
| psw_mchk_i | input | 1 | Status-word machine-check mask |
| psw_ext_i | input | 1 | Status-word external mask |
| psw_io_i | input | 1 | Status-word I/O mask |
| cr_mchk_en_i | input | 1 | Control-register enable for machine checks |
| cr_io_en_i | input | 8 | Control-register enable per I/O subclass |
| mchk_push_i | input | 1 | Enqueue one machine-check request |
| ext_push_i | input | 1 | Enqueue one external request |
| ckc_req_i | input | 1 | Set clock-comparator flag |
| cpt_req_i | input | 1 | Set CPU-timer flag |
| io_push_i | input | 1 | Enqueue one I/O request |
| io_push_sub_i | input | 3 | Subclass of the I/O enqueue |
| grant_o | output | 5 | One-hot grant: bit0 program, bit1 SVC, bit2 mchk, bit3 external, bit4 I/O |
| io_sub_o | output | 3 | Served I/O subclass (0 when no I/O grant) |
| ext_code_o | output | 16 | External interruption code (0 when no external grant) |
| pend_o | output | 3 | Pending flags {I/O, external, machine check} |

## Verification
Two functions can fall in the same cycle: enqueueing into an I/O subclass, and serving that same subclass. The bench fills a subclass to its depth of 4. It then raises a take and a push to that subclass in the same cycle. The serve must be granted and the count must stay at 4, which the bench judges by counting exactly four further grants for the subclass, then a take with no grant. A second case takes the lower classes while a masked-off subclass holds requests: a take must yield no grant while `pend_o[2]` stays high.

// File: rtl/intr_sel_pkg.sv
package intr_sel_pkg;
  typedef enum logic [2:0] {
    CLS_PGM  = 3'd0,
    CLS_SVC  = 3'd1,
    CLS_MCHK = 3'd2,
    CLS_EXT  = 3'd3,
    CLS_IO   = 3'd4
  } cls_e;

  localparam int NUM_CLS = 5;

  typedef enum logic [1:0] {
    EXT_NONE  = 2'd0,
    EXT_QUEUE = 2'd1,
    EXT_CKC   = 2'd2,
    EXT_CPT   = 2'd3
  } ext_src_e;

  localparam logic [15:0] CODE_QUEUED = 16'h0000;
  localparam logic [15:0] CODE_CKC    = 16'h1004;
  localparam logic [15:0] CODE_CPT    = 16'h1005;
endpackage

// File: rtl/intr_qcount.sv
module intr_qcount #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic nonempty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic          full, inc, dec;

  assign full     = (cnt == CW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign dec      = pop && nonempty;
  assign inc      = push && (!full || dec);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (inc && !dec)
      cnt <= cnt + CW'(1);
    else if (dec && !inc)
      cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/intr_io_scan.sv
module intr_io_scan #(
  parameter int NSUB = 8,
  parameter int SW   = 3
) (
  input  logic [NSUB-1:0] nonempty,
  input  logic [NSUB-1:0] enable,
  output logic            hit,
  output logic [SW-1:0]   sub
);
  always_comb begin
    hit = 1'b0;
    sub = '0;
    for (int i = NSUB - 1; i >= 0; i--) begin
      if (nonempty[i] && enable[i]) begin
        hit = 1'b1;
        sub = SW'(i);
      end
    end
  end
endmodule

// File: rtl/intr_ext_pick.sv
module intr_ext_pick
  import intr_sel_pkg::*;
(
  input  logic        queued,
  input  logic        ckc,
  input  logic        cpt,
  output logic        hit,
  output ext_src_e    src,
  output logic [15:0] code
);
  always_comb begin
    hit  = 1'b1;
    src  = EXT_NONE;
    code = CODE_QUEUED;
    if (queued) begin
      src = EXT_QUEUE;
    end else if (ckc) begin
      src  = EXT_CKC;
      code = CODE_CKC;
    end else if (cpt) begin
      src  = EXT_CPT;
      code = CODE_CPT;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/intr_class_sel.sv
module intr_class_sel
  import intr_sel_pkg::*;
#(
  parameter int NSUB  = 8,
  parameter int DEPTH = 4,
  localparam int SW   = $clog2(NSUB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic               pgm_i,
  input  logic               svc_i,
  input  logic               psw_mchk_i,
  input  logic               psw_ext_i,
  input  logic               psw_io_i,
  input  logic               cr_mchk_en_i,
  input  logic [NSUB-1:0]    cr_io_en_i,
  input  logic               mchk_push_i,
  input  logic               ext_push_i,
  input  logic               ckc_req_i,
  input  logic               cpt_req_i,
  input  logic               io_push_i,
  input  logic [SW-1:0]      io_push_sub_i,
  output logic [NUM_CLS-1:0] grant_o,
  output logic [SW-1:0]      io_sub_o,
  output logic [15:0]        ext_code_o,
  output logic [2:0]         pend_o
);
  logic            mchk_ne, ext_ne;
  logic [NSUB-1:0] io_ne, io_push_vec, io_pop_vec;
  logic            pop_mchk, pop_ext, clr_ckc, clr_cpt;
  logic            ckc_q, cpt_q;
  logic            ext_hit, io_hit;
  ext_src_e        ext_src;
  logic [15:0]     ext_code;
  logic [SW-1:0]   io_sel;

  logic [NUM_CLS-1:0] nxt_grant;
  logic [SW-1:0]      nxt_sub;
  logic [15:0]        nxt_code;

  intr_qcount #(.DEPTH(DEPTH)) u_mchk_q (
    .clk(clk), .rst_n(rst_n), .push(mchk_push_i), .pop(pop_mchk), .nonempty(mchk_ne)
  );

  intr_qcount #(.DEPTH(DEPTH)) u_ext_q (
    .clk(clk), .rst_n(rst_n), .push(ext_push_i), .pop(pop_ext), .nonempty(ext_ne)
  );

  for (genvar g = 0; g < NSUB; g++) begin : g_io
    assign io_push_vec[g] = io_push_i && (io_push_sub_i == SW'(g));
    intr_qcount #(.DEPTH(DEPTH)) u_io_q (
      .clk(clk), .rst_n(rst_n), .push(io_push_vec[g]), .pop(io_pop_vec[g]),
      .nonempty(io_ne[g])
    );
  end

  intr_ext_pick u_ext_pick (
    .queued(ext_ne), .ckc(ckc_q), .cpt(cpt_q),
    .hit(ext_hit), .src(ext_src), .code(ext_code)
  );

  intr_io_scan #(.NSUB(NSUB), .SW(SW)) u_io_scan (
    .nonempty(io_ne), .enable(cr_io_en_i), .hit(io_hit), .sub(io_sel)
  );

  // Class decision: synchronous first, then mchk, ext, io.
  always_comb begin
    nxt_grant  = '0;
    nxt_sub    = '0;
    nxt_code   = '0;
    pop_mchk   = 1'b0;
    pop_ext    = 1'b0;
    clr_ckc    = 1'b0;
    clr_cpt    = 1'b0;
    io_pop_vec = '0;
    if (take_i) begin
      if (pgm_i) begin
        nxt_grant[CLS_PGM] = 1'b1;
      end else if (svc_i) begin
        nxt_grant[CLS_SVC] = 1'b1;
      end else if (psw_mchk_i && mchk_ne) begin
        // Disabled in the control register: hold everything, deliver nothing.
        if (cr_mchk_en_i) begin
          nxt_grant[CLS_MCHK] = 1'b1;
          pop_mchk            = 1'b1;
        end
      end else if (psw_ext_i && ext_hit) begin
        nxt_grant[CLS_EXT] = 1'b1;
        nxt_code           = ext_code;
        unique case (ext_src)
          EXT_QUEUE: pop_ext = 1'b1;
          EXT_CKC:   clr_ckc = 1'b1;
          EXT_CPT:   clr_cpt = 1'b1;
          default:   ;
        endcase
      end else if (psw_io_i && io_hit) begin
        nxt_grant[CLS_IO]  = 1'b1;
        nxt_sub            = io_sel;
        io_pop_vec[io_sel] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ckc_q <= 1'b0;
      cpt_q <= 1'b0;
    end else begin
      if (ckc_req_i)    ckc_q <= 1'b1;
      else if (clr_ckc) ckc_q <= 1'b0;
      if (cpt_req_i)    cpt_q <= 1'b1;
      else if (clr_cpt) cpt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_o    <= '0;
      io_sub_o   <= '0;
      ext_code_o <= '0;
    end else begin
      grant_o    <= nxt_grant;
      io_sub_o   <= nxt_sub;
      ext_code_o <= nxt_code;
    end
  end

  assign pend_o = {(|io_ne), (ext_ne || ckc_q || cpt_q), mchk_ne};
endmodule

// File: rtl/intr_class_sel_chk.sv
module intr_class_sel_chk #(
  parameter int NSUB = 8,
  parameter int SW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_i,
  input logic            pgm_i,
  input logic            svc_i,
  input logic            psw_mchk_i,
  input logic            psw_ext_i,
  input logic            psw_io_i,
  input logic            cr_mchk_en_i,
  input logic [NSUB-1:0] cr_io_en_i,
  input logic [4:0]      grant_o,
  input logic [SW-1:0]   io_sub_o,
  input logic [15:0]     ext_code_o,
  input logic [2:0]      pend_o
);
  logic [NSUB-1:0] en_q;
  always_ff @(posedge clk) en_q <= cr_io_en_i;

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R9
  grant_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> $past(take_i));

  // R2
  pgm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && pgm_i) |=> (grant_o == 5'b00001));

  // R3
  mchk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[2] |-> $past(psw_mchk_i && cr_mchk_en_i && !pgm_i && !svc_i));

  // R4
  mchk_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !pgm_i && !svc_i && psw_mchk_i && pend_o[0] && !cr_mchk_en_i)
      |=> (grant_o == '0));

  // R5
  ext_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[3] |-> ($past(psw_ext_i) &&
                    (ext_code_o == 16'h0000 || ext_code_o == 16'h1004 ||
                     ext_code_o == 16'h1005)));

  // R6
  io_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[4] |-> ($past(psw_io_i) && en_q[io_sub_o]));

  // R7
  io_pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o[2]) |-> grant_o[4]);

  // R8
  mchk_pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o[0]) |-> grant_o[2]);

  // R8
  ext_pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o[1]) |-> grant_o[3]);
endmodule

bind intr_class_sel intr_class_sel_chk #(.NSUB(NSUB), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_i(take_i), .pgm_i(pgm_i), .svc_i(svc_i),
  .psw_mchk_i(psw_mchk_i), .psw_ext_i(psw_ext_i), .psw_io_i(psw_io_i),
  .cr_mchk_en_i(cr_mchk_en_i), .cr_io_en_i(cr_io_en_i), .grant_o(grant_o),
  .io_sub_o(io_sub_o), .ext_code_o(ext_code_o), .pend_o(pend_o)
);

// File: tb/intr_class_sel_test.sv
module intr_class_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 0, pgm_i = 0, svc_i = 0;
  logic        psw_mchk_i = 0, psw_ext_i = 0, psw_io_i = 0;
  logic        cr_mchk_en_i = 0;
  logic [7:0]  cr_io_en_i = '0;
  logic        mchk_push_i = 0, ext_push_i = 0, ckc_req_i = 0, cpt_req_i = 0;
  logic        io_push_i = 0;
  logic [2:0]  io_push_sub_i = '0;
  logic [4:0]  grant_o;
  logic [2:0]  io_sub_o;
  logic [15:0] ext_code_o;
  logic [2:0]  pend_o;

  int nchk = 0;
  int nerr = 0;

  localparam logic [4:0] G_NONE = 5'b00000, G_PGM = 5'b00001, G_SVC = 5'b00010,
                         G_MCHK = 5'b00100, G_EXT = 5'b01000, G_IO = 5'b10000;

  always #10 clk = ~clk;

  intr_class_sel uut (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .pgm_i(pgm_i), .svc_i(svc_i),
    .psw_mchk_i(psw_mchk_i), .psw_ext_i(psw_ext_i), .psw_io_i(psw_io_i),
    .cr_mchk_en_i(cr_mchk_en_i), .cr_io_en_i(cr_io_en_i),
    .mchk_push_i(mchk_push_i), .ext_push_i(ext_push_i), .ckc_req_i(ckc_req_i),
    .cpt_req_i(cpt_req_i), .io_push_i(io_push_i), .io_push_sub_i(io_push_sub_i),
    .grant_o(grant_o), .io_sub_o(io_sub_o), .ext_code_o(ext_code_o), .pend_o(pend_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic take_once();
    take_i = 1'b1;
    tick();
    take_i = 1'b0;
  endtask

  task automatic push_io(input logic [2:0] sub);
    io_push_i = 1'b1;
    io_push_sub_i = sub;
    tick();
    io_push_i = 1'b0;
  endtask

  task automatic expect_io(string req, logic [2:0] sub);
    take_once();
    check(req, {27'd0, grant_o}, {27'd0, G_IO});
    check(req, {29'd0, io_sub_o}, {29'd0, sub});
  endtask

  task automatic t_reset();
    tick(); tick();
    check("R1", {27'd0, grant_o}, 0);
    check("R1", {29'd0, pend_o}, 0);
    check("R1", {16'd0, ext_code_o}, 0);
    rst_n = 1'b1;
    tick();
    check("R1", {29'd0, pend_o}, 0);
  endtask

  task automatic t_sync();
    mchk_push_i = 1'b1; tick(); mchk_push_i = 1'b0;
    psw_mchk_i = 1'b1; cr_mchk_en_i = 1'b1;
    pgm_i = 1'b1; svc_i = 1'b1;
    take_once();
    check("R2", {27'd0, grant_o}, {27'd0, G_PGM});
    pgm_i = 1'b0;
    tick();
    check("R9", {27'd0, grant_o}, 0);
    take_once();
    check("R2", {27'd0, grant_o}, {27'd0, G_SVC});
    svc_i = 1'b0;
    check("R2", {29'd0, pend_o}, 3'b001);
    take_once();
    check("R3", {27'd0, grant_o}, {27'd0, G_MCHK});
    check("R8", {29'd0, pend_o}, 0);
    psw_mchk_i = 1'b0; cr_mchk_en_i = 1'b0;
  endtask

  task automatic t_mchk();
    mchk_push_i = 1'b1; ext_push_i = 1'b1; tick();
    mchk_push_i = 1'b0; ext_push_i = 1'b0;
    psw_ext_i = 1'b1;
    take_once();
    check("R3", {27'd0, grant_o}, {27'd0, G_EXT});
    check("R5", {16'd0, ext_code_o}, 32'h0000);
    check("R3", {29'd0, pend_o}, 3'b001);
    psw_mchk_i = 1'b1;
    psw_io_i = 1'b1; cr_io_en_i = 8'hFF;
    push_io(3'd0);
    take_once();
    check("R4", {27'd0, grant_o}, 0);
    check("R4", {29'd0, pend_o}, 3'b101);
    cr_mchk_en_i = 1'b1;
    take_once();
    check("R4", {27'd0, grant_o}, {27'd0, G_MCHK});
    expect_io("R6", 3'd0);
    check("R8", {29'd0, pend_o}, 0);
    take_once();
    check("R9", {27'd0, grant_o}, 0);
  endtask

  task automatic t_ext();
    ckc_req_i = 1'b1; cpt_req_i = 1'b1; ext_push_i = 1'b1; tick();
    ckc_req_i = 1'b0; cpt_req_i = 1'b0; ext_push_i = 1'b0;
    take_once();
    check("R5", {16'd0, ext_code_o}, 32'h0000);
    take_once();
    check("R5", {27'd0, grant_o}, {27'd0, G_EXT});
    check("R5", {16'd0, ext_code_o}, 32'h1004);
    take_once();
    check("R5", {16'd0, ext_code_o}, 32'h1005);
    check("R8", {29'd0, pend_o}, 0);
    take_once();
    check("R8", {27'd0, grant_o}, 0);
  endtask

  task automatic t_io_scan();
    push_io(3'd5); push_io(3'd2); push_io(3'd6);
    cr_io_en_i = 8'b0110_0000;
    expect_io("R6", 3'd5);
    expect_io("R6", 3'd6);
    take_once();
    check("R7", {27'd0, grant_o}, 0);
    check("R7", {29'd0, pend_o}, 3'b100);
    cr_io_en_i = 8'hFF;
    expect_io("R7", 3'd2);
    check("R7", {29'd0, pend_o}, 0);
    push_io(3'd4);
    psw_io_i = 1'b0;
    take_once();
    check("R6", {27'd0, grant_o}, 0);
    psw_io_i = 1'b1;
    expect_io("R6", 3'd4);
  endtask

  task automatic t_depth();
    for (int i = 0; i < 5; i++) push_io(3'd1);
    for (int i = 0; i < 4; i++) expect_io("R10", 3'd1);
    take_once();
    check("R10", {27'd0, grant_o}, 0);
    for (int i = 0; i < 4; i++) push_io(3'd3);
    io_push_i = 1'b1; io_push_sub_i = 3'd3; take_i = 1'b1;
    tick();
    io_push_i = 1'b0; take_i = 1'b0;
    check("R10", {27'd0, grant_o}, {27'd0, G_IO});
    check("R10", {29'd0, io_sub_o}, 3);
    for (int i = 0; i < 4; i++) expect_io("R10", 3'd3);
    take_once();
    check("R10", {27'd0, grant_o}, 0);
    check("R10", {29'd0, pend_o}, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sync();
    t_mchk();
    t_ext();
    t_io_scan();
    t_depth();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule